// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers frame events from a seven-channel display fetch engine and folds them into two sticky status words, one interrupt line and a frame-ID capture register. Each clock the fetch engine may present one channel number and frame ID together with any mix of event pulses: start of frame, end of frame, branch taken, input underrun and bus error. Start and end of frame are gated by the two command bits copied from that channel's current descriptor. Channel 0 and a handful of controller-wide events (last frame done, output underrun, read status, command done, quick-disable acknowledge) land in the primary word. Channels 1 to 6 land in the secondary word.

Software talks to the block through a write-only port with a three-bit select. It sets the controller enable, loads two mask registers and clears status bits by writing ones. The interrupt line is high while any status bit that feeds it is set and not masked. The capture register holds the frame ID of the event that first raised the line. Events that arrive while the line is already high set a "subsequent interrupt" flag and leave the captured ID alone. The status words, the line and the ID are plain outputs for the surrounding register file to read.

Top module: `dsp_irq_stat`

## Requirements
- R1: Reset clears both status words, the ID register, the interrupt line, the enable bit and both masks.
- R2: For channel 0, start of frame sets primary bit 1 only when the descriptor start enable is high, and end of frame sets primary bit 8 only when the descriptor end enable is high. Branch sets bit 9 and underrun sets bit 4. An underrun on channel 1 sets primary bit 5.
- R3: An unmasked start, end or branch event, or any bus error, loads the ID register with the frame ID when the line is low. When the line is high it instead sets primary bit 10 and leaves the ID unchanged.
- R4: For channel c in 1..6, start of frame sets secondary bit c-1, end of frame sets bit c+7 and branch sets bit c+15. Underrun on channels 2..6 sets bit c+23.
- R5: A write with select 3 clears every primary bit in 11:0 that is written as one. Writing bit 2 as one also clears bits 30:28. No other bit changes.
- R6: A write with select 4 clears the secondary bits written as one, but only inside the pattern 0x003E3F3F. Secondary bit 16 and bits 29:24 are not affected by this write.
- R7: The line is high when any primary bit in {0,1,4..9,11,12} is set and its mask bit is clear, or when any secondary bit is set and its mask bit is clear. The primary mask (select 1) uses the same bit positions and keeps only those positions. The secondary mask (select 2) keeps 0x3F3F3F3F. An event whose own mask bit is set neither loads the ID nor sets bit 10.
- R8: A bus error sets primary bit 2 and ORs the channel number into bits 30:28. It updates the ID or bit 10 whatever the masks hold. Bit 2 does not drive the line.
- R9: A write with select 0 stores the enable from bit 0. When it takes a stored one to zero it sets primary bit 7; other control writes leave bit 7 alone.
- R10: When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R11: Channel-tagged events (including bus errors) with channel 7 change nothing.
- R12: Last frame done sets primary bit 0, output underrun bit 6 and command done bit 12, none touching the ID. Read status sets bit 11, and it sets bit 10 only when the line is high and mask bit 11 is clear.
- R13: Status, line and ID take their new values on the first clock edge after the event or write. The line reflects masks written in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 primary mask, 2 secondary mask, 3 primary clear, 4 secondary clear |
| wr_data | input | 32 | Write data |
| ev_ch | input | 3 | Channel the event pulses belong to |
| ev_fid | input | FID_W | Frame ID of that channel's descriptor |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_eof | input | 1 | End-of-frame pulse |
| ev_bs | input | 1 | Branch-taken pulse |
| ev_iu | input | 1 | Input underrun pulse |
| ev_ber | input | 1 | Bus error pulse |
| ev_sof_en | input | 1 | Descriptor command: report start of frame |
| ev_eof_en | input | 1 | Descriptor command: report end of frame |
| ev_ldd | input | 1 | Last frame done pulse |
| ev_ou | input | 1 | Output underrun pulse |
| ev_rdst | input | 1 | Read status pulse |
| ev_cmd | input | 1 | Command done pulse |
| stat0_o | output | 32 | Primary status word |
| stat1_o | output | 32 | Secondary status word |
| irq_id_o | output | FID_W | Captured frame ID |
| irq_o | output | 1 | Interrupt line |

## Verification
Directed phases send start and end events with the descriptor enables both off and on, which separates gating from bit placement. They then sweep every channel from 1 to 6 so that a wrong secondary offset lands on a visibly different bit. Mask patterns are applied before and after events to tell masked bits that are stored but silent from bits that are not recorded at all. Clears are written in the same cycle as events, and clears are aimed at the unclearable secondary positions. Bus errors from two channels expose the OR into the channel field. A long randomized phase mixes all event types, invalid channels and writes. It separates the first-event ID capture from the subsequent flag under dense traffic.

// File: rtl/dsp_irq_pkg.sv
package dsp_irq_pkg;

   // primary status bit positions
   localparam int B_LDD  = 0;
   localparam int B_SOF0 = 1;
   localparam int B_BER  = 2;
   localparam int B_IU0  = 4;
   localparam int B_IU1  = 5;
   localparam int B_OU   = 6;
   localparam int B_QD   = 7;
   localparam int B_EOF0 = 8;
   localparam int B_BS0  = 9;
   localparam int B_SINT = 10;
   localparam int B_RDST = 11;
   localparam int B_CMD  = 12;

   localparam logic [31:0] PRI_CLR     = 32'h0000_0FFF;
   localparam logic [31:0] PRI_IRQ_SRC = 32'h0000_1BF3;
   localparam logic [31:0] BCH_FIELD   = 32'h7000_0000;
   localparam logic [31:0] SEC_CLR     = 32'h003E_3F3F;
   localparam logic [31:0] SEC_MASK_W  = 32'h3F3F_3F3F;

   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_PMASK = 3'd1,
      SEL_SMASK = 3'd2,
      SEL_PSTAT = 3'd3,
      SEL_SSTAT = 3'd4
   } wr_sel_e;

   // secondary status positions for channel c (1..6)
   function automatic int sec_sof(input int c); return c - 1;  endfunction
   function automatic int sec_eof(input int c); return c + 7;  endfunction
   function automatic int sec_bs (input int c); return c + 15; endfunction
   function automatic int sec_iu (input int c); return c + 23; endfunction

endpackage

// File: rtl/dsp_irq_evt_dec.sv
module dsp_irq_evt_dec
   import dsp_irq_pkg::*;
#(
   parameter int NUM_CH = 7
) (
   input  logic [2:0]  ev_ch,
   input  logic        ev_sof,
   input  logic        ev_eof,
   input  logic        ev_bs,
   input  logic        ev_iu,
   input  logic        ev_ber,
   input  logic        ev_sof_en,
   input  logic        ev_eof_en,
   input  logic [31:0] pmask,
   input  logic [31:0] smask,
   output logic [31:0] pset,
   output logic [31:0] sset,
   output logic        id_hit
);

   logic ch_ok, sof_g, eof_g, bs_g, iu_g, ber_g;
   logic [NUM_CH-1:0][31:0] p_ch;
   logic [NUM_CH-1:0][31:0] s_ch;
   logic [NUM_CH-1:0]       um_ch;
   logic                    unused_mask_bits;

   assign ch_ok = (ev_ch < 3'(NUM_CH));
   assign sof_g = ev_sof & ev_sof_en & ch_ok;
   assign eof_g = ev_eof & ev_eof_en & ch_ok;
   assign bs_g  = ev_bs  & ch_ok;
   assign iu_g  = ev_iu  & ch_ok;
   assign ber_g = ev_ber & ch_ok;
   assign unused_mask_bits = ^{pmask, smask};

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit, sof_h, eof_h, bs_h, iu_h;
      assign hit   = (ev_ch == 3'(g));
      assign sof_h = sof_g & hit;
      assign eof_h = eof_g & hit;
      assign bs_h  = bs_g  & hit;
      assign iu_h  = iu_g  & hit;
      if (g == 0) begin : g_prim
         assign p_ch[g] = (32'(sof_h) << B_SOF0) | (32'(eof_h) << B_EOF0)
                        | (32'(bs_h)  << B_BS0)  | (32'(iu_h)  << B_IU0);
         assign s_ch[g] = '0;
         assign um_ch[g] = (sof_h & ~pmask[B_SOF0]) | (eof_h & ~pmask[B_EOF0])
                         | (bs_h & ~pmask[B_BS0]);
      end else begin : g_sec
         if (g == 1) begin : g_iu_prim
            assign p_ch[g] = 32'(iu_h) << B_IU1;
            assign s_ch[g] = (32'(sof_h) << sec_sof(g)) | (32'(eof_h) << sec_eof(g))
                           | (32'(bs_h) << sec_bs(g));
         end else begin : g_iu_sec
            assign p_ch[g] = '0;
            assign s_ch[g] = (32'(sof_h) << sec_sof(g)) | (32'(eof_h) << sec_eof(g))
                           | (32'(bs_h) << sec_bs(g)) | (32'(iu_h) << sec_iu(g));
         end
         assign um_ch[g] = (sof_h & ~smask[sec_sof(g)]) | (eof_h & ~smask[sec_eof(g)])
                         | (bs_h & ~smask[sec_bs(g)]);
      end
   end

   always_comb begin
      pset = '0;
      sset = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         pset = pset | p_ch[i];
         sset = sset | s_ch[i];
      end
      pset[B_BER]  = ber_g;
      pset[30:28]  = ber_g ? ev_ch : 3'd0;
   end

   assign id_hit = (|um_ch) | ber_g;

endmodule

// File: rtl/dsp_irq_w1c.sv
module dsp_irq_w1c #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] nxt_o
);

   // set wins over clear in the same cycle
   assign nxt_o = (q_o & ~clr_i) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt_o;
   end

endmodule

// File: rtl/dsp_irq_stat.sv
module dsp_irq_stat
   import dsp_irq_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int FID_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       ev_ch,
   input  logic [FID_W-1:0] ev_fid,
   input  logic             ev_sof,
   input  logic             ev_eof,
   input  logic             ev_bs,
   input  logic             ev_iu,
   input  logic             ev_ber,
   input  logic             ev_sof_en,
   input  logic             ev_eof_en,
   input  logic             ev_ldd,
   input  logic             ev_ou,
   input  logic             ev_rdst,
   input  logic             ev_cmd,
   output logic [31:0]      stat0_o,
   output logic [31:0]      stat1_o,
   output logic [FID_W-1:0] irq_id_o,
   output logic             irq_o
);

   if (NUM_CH < 2 || NUM_CH > 7) begin : g_bad_ch
      $error("dsp_irq_stat: NUM_CH must be 2..7");
   end
   if (FID_W < 1) begin : g_bad_fid
      $error("dsp_irq_stat: FID_W must be positive");
   end

   logic        en_q;
   logic [31:0] pmask_q, smask_q, pmask_d, smask_d;
   logic        wr_ctrl, wr_pstat, wr_sstat;
   logic [31:0] dec_pset, dec_sset, pset_all, pclr, sclr;
   logic [31:0] p_nxt, s_nxt;
   logic        dec_hit, qd_set, sint_set, irq_d;

   assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
   assign wr_pstat = wr_en && (wr_sel == SEL_PSTAT);
   assign wr_sstat = wr_en && (wr_sel == SEL_SSTAT);

   always_comb begin
      pmask_d = (wr_en && wr_sel == SEL_PMASK) ? (wr_data & PRI_IRQ_SRC) : pmask_q;
      smask_d = (wr_en && wr_sel == SEL_SMASK) ? (wr_data & SEC_MASK_W)  : smask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         pmask_q <= '0;
         smask_q <= '0;
      end else begin
         if (wr_ctrl) en_q <= wr_data[0];
         pmask_q <= pmask_d;
         smask_q <= smask_d;
      end
   end

   dsp_irq_evt_dec #(.NUM_CH(NUM_CH)) u_dec (
      .ev_ch     (ev_ch),
      .ev_sof    (ev_sof),
      .ev_eof    (ev_eof),
      .ev_bs     (ev_bs),
      .ev_iu     (ev_iu),
      .ev_ber    (ev_ber),
      .ev_sof_en (ev_sof_en),
      .ev_eof_en (ev_eof_en),
      .pmask     (pmask_q),
      .smask     (smask_q),
      .pset      (dec_pset),
      .sset      (dec_sset),
      .id_hit    (dec_hit)
   );

   assign qd_set   = wr_ctrl & en_q & ~wr_data[0];
   assign sint_set = irq_o & (dec_hit | (ev_rdst & ~pmask_q[B_RDST]));

   always_comb begin
      pset_all         = dec_pset;
      pset_all[B_LDD]  = pset_all[B_LDD] | ev_ldd;
      pset_all[B_OU]   = pset_all[B_OU] | ev_ou;
      pset_all[B_QD]   = pset_all[B_QD] | qd_set;
      pset_all[B_SINT] = pset_all[B_SINT] | sint_set;
      pset_all[B_RDST] = pset_all[B_RDST] | ev_rdst;
      pset_all[B_CMD]  = pset_all[B_CMD] | ev_cmd;
      pclr = wr_pstat ? ((wr_data & PRI_CLR) | (wr_data[B_BER] ? BCH_FIELD : 32'h0)) : 32'h0;
      sclr = wr_sstat ? (wr_data & SEC_CLR) : 32'h0;
   end

   dsp_irq_w1c #(.W(32)) u_pri (
      .clk (clk), .rst_n (rst_n), .set_i (pset_all), .clr_i (pclr),
      .q_o (stat0_o), .nxt_o (p_nxt)
   );

   dsp_irq_w1c #(.W(32)) u_sec (
      .clk (clk), .rst_n (rst_n), .set_i (dec_sset), .clr_i (sclr),
      .q_o (stat1_o), .nxt_o (s_nxt)
   );

   assign irq_d = (|(p_nxt & ~pmask_d & PRI_IRQ_SRC)) | (|(s_nxt & ~smask_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o    <= 1'b0;
         irq_id_o <= '0;
      end else begin
         irq_o <= irq_d;
         if (dec_hit && !irq_o) irq_id_o <= ev_fid;
      end
   end

endmodule

// File: rtl/dsp_irq_stat_chk.sv
module dsp_irq_stat_chk #(
   parameter int NUM_CH = 7,
   parameter int FID_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       wr_sel,
   input logic [31:0]      wr_data,
   input logic [2:0]       ev_ch,
   input logic             ev_sof,
   input logic             ev_sof_en,
   input logic             ev_ber,
   input logic             en_q,
   input logic [31:0]      stat0_o,
   input logic [31:0]      stat1_o,
   input logic [FID_W-1:0] irq_id_o,
   input logic             irq_o
);

   AST_ID_FROZEN_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> $stable(irq_id_o)); // R3

   AST_BER_SUBSEQUENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_ber && ev_ch < 3'(NUM_CH) && irq_o) |=> stat0_o[10]); // R8

   AST_BER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat0_o[2] && !(wr_en && wr_sel == 3'd3 && wr_data[2])) |=> stat0_o[2]); // R5

   AST_QD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0 && en_q && !wr_data[0]) |=> stat0_o[7]); // R9

   AST_SOF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ev_sof && ev_sof_en) && !stat0_o[1]) |=> !stat0_o[1]); // R2

   AST_UNDERRUN_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat1_o[29:24] & $past(stat1_o[29:24])) == $past(stat1_o[29:24]))); // R6

endmodule

bind dsp_irq_stat dsp_irq_stat_chk #(.NUM_CH(NUM_CH), .FID_W(FID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .ev_ch     (ev_ch),
   .ev_sof    (ev_sof),
   .ev_sof_en (ev_sof_en),
   .ev_ber    (ev_ber),
   .en_q      (en_q),
   .stat0_o   (stat0_o),
   .stat1_o   (stat1_o),
   .irq_id_o  (irq_id_o),
   .irq_o     (irq_o)
);

// File: tb/dsp_irq_stat_tb.sv
`timescale 1ns/1ps
module dsp_irq_stat_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  ev_ch = '0;
   logic [31:0] ev_fid = '0;
   logic ev_sof = 0, ev_eof = 0, ev_bs = 0, ev_iu = 0, ev_ber = 0;
   logic ev_sof_en = 0, ev_eof_en = 0, ev_ldd = 0, ev_ou = 0, ev_rdst = 0, ev_cmd = 0;
   logic [31:0] stat0_o, stat1_o, irq_id_o;
   logic        irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   dsp_irq_stat #(.NUM_CH(7), .FID_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ev_ch(ev_ch), .ev_fid(ev_fid), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_bs(ev_bs),
      .ev_iu(ev_iu), .ev_ber(ev_ber), .ev_sof_en(ev_sof_en), .ev_eof_en(ev_eof_en),
      .ev_ldd(ev_ldd), .ev_ou(ev_ou), .ev_rdst(ev_rdst), .ev_cmd(ev_cmd),
      .stat0_o(stat0_o), .stat1_o(stat1_o), .irq_id_o(irq_id_o), .irq_o(irq_o)
   );

   // behavioural reference model
   logic [31:0] m_p, m_s, m_id, m_pm, m_sm;
   logic        m_irq, m_en;

   always @(posedge clk) begin
      logic [31:0] np, ns, npm, nsm, nid;
      logic        nen, unm;
      int          c;
      if (!rst_n) begin
         m_p <= 0; m_s <= 0; m_id <= 0; m_pm <= 0; m_sm <= 0; m_irq <= 0; m_en <= 0;
      end else begin
         np = m_p; ns = m_s; npm = m_pm; nsm = m_sm; nid = m_id; nen = m_en; unm = 0;
         if (wr_en) begin
            case (wr_sel)
               3'd0: begin
                  if (m_en && !wr_data[0]) np[7] = 1;
                  nen = wr_data[0];
               end
               3'd1: npm = wr_data & 32'h1BF3;
               3'd2: nsm = wr_data & 32'h3F3F3F3F;
               3'd3: begin
                  np = np & ~(wr_data & 32'hFFF);
                  if (wr_data[2]) np[30:28] = 3'd0;
               end
               3'd4: ns = ns & ~(wr_data & 32'h3E3F3F);
               default: ;
            endcase
         end
         c = int'(ev_ch);
         if (c < 7) begin
            if (ev_sof && ev_sof_en) begin
               if (c == 0) begin np[1] = 1; if (!m_pm[1]) unm = 1; end
               else begin ns[c-1] = 1; if (!m_sm[c-1]) unm = 1; end
            end
            if (ev_eof && ev_eof_en) begin
               if (c == 0) begin np[8] = 1; if (!m_pm[8]) unm = 1; end
               else begin ns[c+7] = 1; if (!m_sm[c+7]) unm = 1; end
            end
            if (ev_bs) begin
               if (c == 0) begin np[9] = 1; if (!m_pm[9]) unm = 1; end
               else begin ns[c+15] = 1; if (!m_sm[c+15]) unm = 1; end
            end
            if (ev_iu) begin
               if (c == 0) np[4] = 1;
               else if (c == 1) np[5] = 1;
               else ns[c+23] = 1;
            end
            if (ev_ber) begin
               np[2] = 1;
               np[30:28] = np[30:28] | ev_ch;
               unm = 1;
            end
         end
         if (ev_ldd) np[0] = 1;
         if (ev_ou) np[6] = 1;
         if (ev_cmd) np[12] = 1;
         if (ev_rdst) begin
            np[11] = 1;
            if (!m_pm[11] && m_irq) np[10] = 1;
         end
         if (unm) begin
            if (m_irq) np[10] = 1;
            else nid = ev_fid;
         end
         m_p <= np; m_s <= ns; m_pm <= npm; m_sm <= nsm; m_en <= nen; m_id <= nid;
         m_irq <= (|(np & ~npm & 32'h1BF3)) || (|(ns & ~nsm));
      end
   end

   task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      check1("stat0", stat0_o, m_p);
      check1("stat1", stat1_o, m_s);
      check1("irq_id", irq_id_o, m_id);
      check1("irq", {31'b0, irq_o}, {31'b0, m_irq});
   endtask

   task automatic idle();
      wr_en = 0; ev_sof = 0; ev_eof = 0; ev_bs = 0; ev_iu = 0; ev_ber = 0;
      ev_sof_en = 0; ev_eof_en = 0; ev_ldd = 0; ev_ou = 0; ev_rdst = 0; ev_cmd = 0;
   endtask

   task automatic evt(input int ch, input logic [31:0] fid, input logic s, input logic e,
                      input logic b, input logic u, input logic r, input logic se, input logic ee);
      ev_ch = 3'(ch); ev_fid = fid; ev_sof = s; ev_eof = e; ev_bs = b; ev_iu = u; ev_ber = r;
      ev_sof_en = se; ev_eof_en = ee;
      cyc();
      idle();
   endtask

   task automatic wr(input int sel, input logic [31:0] d);
      wr_en = 1; wr_sel = 3'(sel); wr_data = d;
      cyc();
      idle();
   endtask

   task automatic misc(input logic l, input logic o, input logic r, input logic c);
      ev_ldd = l; ev_ou = o; ev_rdst = r; ev_cmd = c;
      cyc();
      idle();
   endtask

   task automatic clear_all();
      wr(3, 32'hFFFF_FFFF);
      wr(4, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle();
      cur_req = "R1";
      repeat (3) cyc();
      rst_n = 1;
      cyc();

      cur_req = "R2";
      evt(0, 32'h11, 1, 0, 0, 0, 0, 0, 1);   // sof with start enable off
      evt(0, 32'h22, 0, 1, 0, 0, 0, 1, 0);   // eof with end enable off
      evt(0, 32'hA1, 1, 0, 0, 0, 0, 1, 0);   // recorded, loads ID
      cur_req = "R3";
      evt(3, 32'hB3, 0, 1, 0, 0, 0, 0, 1);   // line high: subsequent flag
      evt(0, 32'hC0, 0, 1, 1, 1, 0, 0, 1);
      cur_req = "R2";
      evt(1, 32'hC1, 0, 0, 0, 1, 0, 0, 0);
      clear_all();

      cur_req = "R4";
      for (int ch = 1; ch < 7; ch++) begin
         evt(ch, 32'h100 + ch, 1, 0, 0, 0, 0, 1, 0);
         evt(ch, 32'h200 + ch, 0, 1, 0, 0, 0, 0, 1);
         evt(ch, 32'h300 + ch, 0, 0, 1, 1, 0, 0, 0);
      end
      cur_req = "R6";
      wr(4, 32'hFFFF_FFFF);
      wr(4, 32'h0100_0001);
      cur_req = "R7";
      wr(2, 32'hFFFF_FFFF);
      wr(3, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
      evt(0, 32'hD0, 1, 1, 1, 0, 0, 1, 1);   // masked: stored, silent
      evt(4, 32'hD4, 1, 1, 1, 0, 0, 1, 1);
      wr(1, 32'h0000_0200);                   // unmask all but branch
      wr(1, 32'h0);
      wr(3, 32'hFFF);
      wr(2, 32'h0);
      wr(2, 32'h3F3F3F3F);

      cur_req = "R5";
      evt(5, 32'hE5, 0, 0, 0, 0, 1, 0, 0);
      evt(2, 32'hE2, 0, 0, 0, 0, 1, 0, 0);
      wr(3, 32'h0000_0001);
      wr(3, 32'h0000_0004);
      cur_req = "R8";
      wr(1, 32'hFFFF_FFFF);
      evt(6, 32'hF6, 0, 0, 0, 0, 1, 0, 0);
      evt(1, 32'hF1, 0, 0, 0, 0, 1, 0, 0);
      wr(3, 32'hFFF);
      wr(1, 32'h0);

      cur_req = "R9";
      wr(0, 32'h1);
      wr(0, 32'h1);
      wr(0, 32'h0);
      wr(3, 32'h80);
      wr(0, 32'h0);

      cur_req = "R10";
      ev_ch = 0; ev_fid = 32'h77; ev_sof = 1; ev_sof_en = 1;
      wr_en = 1; wr_sel = 3'd3; wr_data = 32'hFFF;
      cyc(); idle();
      wr(3, 32'hFFF);

      cur_req = "R11";
      evt(7, 32'h99, 1, 1, 1, 1, 1, 1, 1);

      cur_req = "R12";
      misc(1, 1, 0, 1);
      misc(0, 0, 1, 0);
      wr(3, 32'hFFF);
      evt(0, 32'h55, 1, 0, 0, 0, 0, 1, 0);
      misc(0, 0, 1, 0);
      wr(1, 32'h800);
      wr(3, 32'h400);
      misc(0, 0, 1, 0);
      wr(1, 32'h0);
      clear_all();

      cur_req = "R13";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 15);
         ev_ch = 3'($urandom_range(0, 7)); ev_fid = $urandom;
         ev_sof = ($urandom_range(0, 3) == 0); ev_eof = ($urandom_range(0, 3) == 0);
         ev_bs = ($urandom_range(0, 5) == 0); ev_iu = ($urandom_range(0, 9) == 0);
         ev_ber = ($urandom_range(0, 9) == 0);
         ev_sof_en = $urandom_range(0, 1); ev_eof_en = $urandom_range(0, 1);
         ev_ldd = ($urandom_range(0, 15) == 0); ev_ou = ($urandom_range(0, 15) == 0);
         ev_rdst = ($urandom_range(0, 9) == 0); ev_cmd = ($urandom_range(0, 15) == 0);
         if (r < 5) begin
            wr_en = 1; wr_sel = 3'($urandom_range(0, 4)); wr_data = $urandom;
         end
         cyc();
         idle();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule